// File: doc/BRIEF.md
# Pulse-Width Charge Digitizer

This block turns nine discriminator pulses into digital charge estimates by measuring how many clock cycles each pulse stays high. Eight of the inputs come from summed pixel groups and are measured with 7-bit counters. The ninth input comes from the last dynode and gets an 8-bit counter. Each input is first passed through a two-stage synchronizer. After that, a small per-channel state machine times the first pulse of the current acquisition frame and ignores any pulse that follows it.

A one-cycle frame strobe closes the frame and opens the next one. In the strobe cycle the nine results are captured into a 66-bit word and all counters are re-armed. The word is then shifted out on one serial line, one bit per clock. It starts with a start bit, carries 64 data bits and ends with an even parity bit. After the last bit the line returns to its idle low level. With expected pulse widths between 25 ns and 2450 ns and a clock in the 100 MHz range, both measurement and readout fit inside a 2.5 µs frame.

Top module: `tot_digitizer`

## Requirements
- R1: Each channel reports the number of clock cycles its input was high during the frame. A channel that saw no pulse reports 0.
- R2: A sum channel saturates and reports 127 for any pulse of 127 cycles or longer.
- R3: The dynode channel saturates and reports 255 for any pulse of 255 cycles or longer. A 250-cycle pulse reports 250.
- R4: Only the first pulse on a channel is measured in each frame. Pulses that arrive after it ends, up to the next frame strobe, do not change the reported value.
- R5: A frame strobe that is high for one cycle captures the results. The counters restart from zero, so results do not carry over into the next frame.
- R6: The serial word is sent MSB first, one bit per clock, starting the cycle after the strobe. The order is: a start bit of 1, sum channels 0 to 7 (7 bits each, MSB first), the dynode value (8 bits, MSB first), then the parity bit. That makes 66 bits in total.
- R7: The last bit is even parity over the 64 data bits, so the XOR of the data bits and the parity bit is 0.
- R8: The serial line is 0 after reset and returns to 0 once all 66 bits have been sent.
- R9: Inputs pass through two register stages before they are measured. A pulse that rises in the cycle of the frame strobe is counted in full in the following frame and not at all in the closing one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_i | input | 1 | One-cycle strobe that ends the current frame |
| sum_pulse_i | input | 8 | Discriminator pulses of the summed-pixel channels |
| dyn_pulse_i | input | 1 | Discriminator pulse of the dynode channel |
| ser_o | output | 1 | Serial result word, MSB first |

## Verification
The bench builds the block with its default widths: eight 7-bit sum channels and one 8-bit dynode channel. With these widths every field value and both saturation points can be reached within a few hundred cycles per frame. A sweep of frames drives widths from 0 to beyond both limits on all nine channels at once. It decodes every field, the start bit and the parity from the serial line. Extra frames add second pulses after the first one, widths right at 127/128 and 255/256, and a pulse that starts together with the strobe, which exposes the synchronizer latency.

// File: rtl/tot_pkg.sv
package tot_pkg;

    localparam int unsigned SUM_CH  = 8;
    localparam int unsigned SUM_BITS = 7;
    localparam int unsigned DYN_BITS = 8;

    typedef enum logic [1:0] {
        CH_ARMED = 2'd0,
        CH_MEAS  = 2'd1,
        CH_DONE  = 2'd2
    } ch_state_e;

    function automatic int unsigned data_bits(int unsigned nch, int unsigned sw, int unsigned dw);
        return nch * sw + dw;
    endfunction

endpackage

// File: rtl/tot_sync.sv
module tot_sync #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d_i;
            stage2 <= stage1;
        end
    end

    assign q_o = stage2;
endmodule

// File: rtl/tot_width_ctr.sv
module tot_width_ctr
    import tot_pkg::*;
#(
    parameter int unsigned W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         pulse_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    ch_state_e    st;
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            st  <= CH_ARMED;
            cnt <= '0;
        end else begin
            case (st)
                CH_ARMED: begin
                    if (pulse_i) begin
                        cnt <= {{(W-1){1'b0}}, 1'b1};
                        st  <= CH_MEAS;
                    end
                end
                CH_MEAS: begin
                    if (pulse_i) begin
                        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
                    end else begin
                        st <= CH_DONE;
                    end
                end
                default: st <= CH_DONE;
            endcase
        end
    end

    assign cnt_o = cnt;

    // R2 for sum channels, R3 for the dynode channel
    assert_hold_max_R2: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_MAX && !clr_i) |=> cnt == CNT_MAX);

    assert_first_only_R4: assert property (@(posedge clk) disable iff (rst)
        (st == CH_DONE && !clr_i) |=> $stable(cnt));

    assert_restart_R5: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (cnt == '0 && st == CH_ARMED));

    assert_monotonic_R1: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && st != CH_ARMED) |=> cnt >= $past(cnt));
endmodule

// File: rtl/tot_serializer.sv
module tot_serializer #(
    parameter int unsigned FW = 66
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [FW-1:0] word_i,
    output logic          ser_o
);
    localparam int unsigned RW = $clog2(FW + 1);

    logic [FW-1:0] shreg;
    logic [RW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg  <= '0;
            remain <= '0;
        end else if (load_i) begin
            shreg  <= word_i;
            remain <= RW'(FW);
        end else if (remain != '0) begin
            shreg  <= {shreg[FW-2:0], 1'b0};
            remain <= remain - 1'b1;
        end
    end

    assign ser_o = shreg[FW-1];

    assert_start_bit_R6: assert property (@(posedge clk) disable iff (rst)
        load_i |=> ser_o);

    assert_idle_low_R8: assert property (@(posedge clk) disable iff (rst)
        (remain == '0) |-> !ser_o);
endmodule

// File: rtl/tot_digitizer.sv
module tot_digitizer
    import tot_pkg::*;
#(
    parameter int unsigned N_SUM = SUM_CH,
    parameter int unsigned SUM_W = SUM_BITS,
    parameter int unsigned DYN_W = DYN_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_i,
    input  logic [N_SUM-1:0] sum_pulse_i,
    input  logic             dyn_pulse_i,
    output logic             ser_o
);
    localparam int unsigned DATA_W  = data_bits(N_SUM, SUM_W, DYN_W);
    localparam int unsigned FRAME_W = DATA_W + 2;
    localparam int unsigned NIN     = N_SUM + 1;

    logic [NIN-1:0]   raw_in;
    logic [NIN-1:0]   sync_in;
    logic [SUM_W-1:0] sum_cnt [N_SUM];
    logic [DYN_W-1:0] dyn_cnt;
    logic [DATA_W-1:0] data_word;
    logic [FRAME_W-1:0] frame_word;

    assign raw_in = {dyn_pulse_i, sum_pulse_i};

    tot_sync #(.W(NIN)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_in),
        .q_o (sync_in)
    );

    for (genvar g = 0; g < N_SUM; g++) begin : g_sum
        tot_width_ctr #(.W(SUM_W)) u_ctr (
            .clk     (clk),
            .rst     (rst),
            .clr_i   (frame_i),
            .pulse_i (sync_in[g]),
            .cnt_o   (sum_cnt[g])
        );
    end

    tot_width_ctr #(.W(DYN_W)) u_dyn_ctr (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (frame_i),
        .pulse_i (sync_in[N_SUM]),
        .cnt_o   (dyn_cnt)
    );

    always_comb begin
        data_word = '0;
        for (int i = 0; i < int'(N_SUM); i++) begin
            data_word[DATA_W-1 - i*SUM_W -: SUM_W] = sum_cnt[i];
        end
        data_word[DYN_W-1:0] = dyn_cnt;
        frame_word = {1'b1, data_word, ^data_word};
    end

    tot_serializer #(.FW(FRAME_W)) u_ser (
        .clk    (clk),
        .rst    (rst),
        .load_i (frame_i),
        .word_i (frame_word),
        .ser_o  (ser_o)
    );
endmodule

// File: tb/tot_digitizer_bench.sv
module tot_digitizer_bench;
    localparam int NS = 8;
    localparam int SMAX = 127;
    localparam int DMAX = 255;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame = 1'b0;
    logic [NS-1:0] sum_p = '0;
    logic dyn_p = 1'b0;
    logic ser;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    int w1 [9];
    int w2 [9];
    int gap = 0;
    int exp_v [9];

    always #5 clk = ~clk;

    tot_digitizer u_tot_digitizer (
        .clk(clk), .rst(rst), .frame_i(frame),
        .sum_pulse_i(sum_p), .dyn_pulse_i(dyn_p), .ser_o(ser)
    );

    task automatic chk(string tag, int act, int expv);
        tests++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    function automatic int sat(int v, int m);
        return (v > m) ? m : v;
    endfunction

    task automatic set_exp_from_w1();
        for (int c = 0; c < 9; c++) exp_v[c] = sat(w1[c], (c < NS) ? SMAX : DMAX);
    endtask

    // drive first pulse from cycle 1, optional second after gap
    task automatic drive_pulses();
        int m1 = 0;
        int m2 = 0;
        int total;
        for (int c = 0; c < 9; c++) begin
            if (w1[c] > m1) m1 = w1[c];
            if (w2[c] > m2) m2 = w2[c];
        end
        total = 1 + m1 + gap + m2 + 5;
        for (int t = 0; t < total; t++) begin
            @(negedge clk);
            for (int c = 0; c < 9; c++) begin
                bit h;
                h = (t >= 1 && t < 1 + w1[c]) ||
                    (w2[c] > 0 && t >= 1 + w1[c] + gap && t < 1 + w1[c] + gap + w2[c]);
                if (c < NS) sum_p[c] = h; else dyn_p = h;
            end
        end
        sum_p = '0;
        dyn_p = 1'b0;
    endtask

    // strobe, then decode 66 serial bits; r9 raises ch0 and dynode with the strobe
    task automatic read_check(string tag, bit r9);
        logic [65:0] cap;
        int par;
        @(negedge clk);
        frame = 1'b1;
        if (r9) begin
            sum_p[0] = 1'b1;
            dyn_p = 1'b1;
        end
        for (int i = 0; i < 66; i++) begin
            @(negedge clk);
            if (i == 0) frame = 1'b0;
            if (r9 && i == 4) begin
                sum_p[0] = 1'b0;
                dyn_p = 1'b0;
            end
            cap[65-i] = ser;
        end
        chk({tag, " R6 start bit"}, int'(cap[65]), 1);
        for (int c = 0; c < NS; c++)
            chk($sformatf("%s R1/R2 sum%0d", tag, c), int'(cap[64 - c*7 -: 7]), exp_v[c]);
        chk({tag, " R1/R3 dynode"}, int'(cap[8:1]), exp_v[8]);
        par = 0;
        for (int c = 0; c < NS; c++) par ^= ^(exp_v[c] & 32'h7f);
        par ^= ^(exp_v[8] & 32'hff);
        chk({tag, " R7 parity"}, int'(cap[0]), par);
        @(negedge clk);
        chk({tag, " R8 idle after word"}, int'(ser), 0);
    endtask

    task automatic clear_w();
        for (int c = 0; c < 9; c++) begin
            w1[c] = 0;
            w2[c] = 0;
        end
        gap = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R8 reset line low", int'(ser), 0);

        // empty frame
        clear_w();
        drive_pulses();
        set_exp_from_w1();
        read_check("empty R1", 1'b0);

        // sweep of widths across all channels, through both saturation points (R2, R3)
        for (int k = 0; k < 30; k++) begin
            clear_w();
            for (int c = 0; c < NS; c++) w1[c] = (k * 13 + c * 29) % 150;
            w1[8] = (k * 37 + 5) % 300;
            drive_pulses();
            set_exp_from_w1();
            read_check($sformatf("sweep%0d", k), 1'b0);
        end

        // exact boundaries R2 R3
        clear_w();
        w1[0] = 126; w1[1] = 127; w1[2] = 128; w1[3] = 1;
        w1[4] = 2;   w1[5] = 64;  w1[6] = 200; w1[7] = 0;
        w1[8] = 255;
        drive_pulses();
        set_exp_from_w1();
        read_check("bound255 R2 R3", 1'b0);
        clear_w();
        w1[8] = 256; w1[0] = 300;
        drive_pulses();
        set_exp_from_w1();
        read_check("bound256 R3", 1'b0);
        clear_w();
        w1[8] = 250;
        drive_pulses();
        set_exp_from_w1();
        read_check("dyn250 R3", 1'b0);

        // later pulses ignored R4
        for (int k = 0; k < 4; k++) begin
            clear_w();
            gap = 2 + k;
            for (int c = 0; c < 9; c++) begin
                w1[c] = 3 + c * 5 + k;
                w2[c] = 40 + k * 10;
            end
            drive_pulses();
            set_exp_from_w1();
            read_check($sformatf("second pulse R4 %0d", k), 1'b0);
        end

        // pulse rising with strobe lands in the next frame R9, and R5 restart
        clear_w();
        for (int c = 0; c < 9; c++) exp_v[c] = 0;
        read_check("strobe-aligned R9", 1'b1);
        clear_w();
        drive_pulses();
        for (int c = 0; c < 9; c++) exp_v[c] = 0;
        exp_v[0] = 5;
        exp_v[8] = 5;
        read_check("next frame R9", 1'b0);
        clear_w();
        drive_pulses();
        for (int c = 0; c < 9; c++) exp_v[c] = 0;
        read_check("no carry-over R5", 1'b0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule